// File: doc/BRIEF.md
# Per-Sector Flash Access Lock Controller

This block keeps the protection state of each sector in a parallel flash array and applies it to every array access. Each sector owns a small lock register with three stored bits: a read lock, a write lock and a one-time lock-down. Software reads and writes these registers through a simple select/write/read-data port. Array accesses arrive with a sector index. Read data from the array is passed through, or forced to all zeros when the addressed sector is read-locked. A program or erase request is either granted or blocked. A blocked request raises a sticky sector-lock error flag that feeds the status register.

Two active-low hardware protect pins override the stored write locks. The top-block pin covers the highest-numbered sector and the write-protect pin covers all the other sectors. The pins never appear in the lock register read value.

Each sector register is a two-state machine. `SEC_OPEN` is entered at reset or init. Its only transition, OPEN->FROZEN, is taken on a register write that sets the lock-down bit. `SEC_FROZEN` has no exit other than reset or init. The error flag is also a two-state machine. `ERR_IDLE` moves to `ERR_FLAG` (IDLE->FLAG) when a program or erase request is blocked. `ERR_FLAG` returns to `ERR_IDLE` (FLAG->IDLE) on a clear strobe, provided no new blocked request arrives in the same cycle. Both machines return to their initial state on the asynchronous reset or on the synchronous init input.

Top module: `sector_lock_ctl`

## Requirements
- R1: After reset every lock register reads 0x01: write lock 1, lock-down 0, read lock 0. The error flag reads 0.
- R2: Lock register layout: bit 0 is the write lock, bit 1 is the lock-down bit and bit 2 is the read lock. Bits 7:3 always read 0. A write to a sector that is not locked down stores write-data bits 2:0, and the new value reads back from the next cycle.
- R3: When the addressed sector's read lock is 1, `rd_data` is 0x00. Otherwise `rd_data` equals `arr_rdata`. A locked read never sets the error flag.
- R4: A program or erase request (`pe_req`) to a sector that is effectively write-locked leaves `pe_go` at 0 and sets `lock_err` on the following cycle. A request to a sector that is not write-locked gives `pe_go`=1.
- R5: Once a sector's lock-down bit is 1, all later writes to that sector's register are ignored, including writes that try to clear lock-down. The read-lock and write-lock bits keep their values.
- R6: Driving `init_n` low for one clock edge restores every register and the error flag to the R1 values, and it clears lock-down.
- R7: With `tbl_n` low, sector 7 is write-locked whatever its register holds. With `wp_n` low, sectors 0 to 6 are write-locked whatever their registers hold. Neither pin changes `reg_rdata`.
- R8: A register write in the same cycle as an access to the same sector does not affect that access. The new value governs accesses from the next cycle.
- R9: `lock_err` stays 1 until a cycle with `clr_sts`=1. If a blocked request coincides with `clr_sts`, the flag is 1 on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| init_n | input | 1 | Synchronous active-low device init, same effect as reset |
| tbl_n | input | 1 | Active-low top-sector write protect |
| wp_n | input | 1 | Active-low write protect for all other sectors |
| reg_wr | input | 1 | Lock register write strobe |
| reg_sel | input | 3 | Sector whose lock register is written or read |
| reg_wdata | input | 8 | Lock register write data |
| reg_rdata | output | 8 | Lock register read value of `reg_sel` |
| acc_sector | input | 3 | Sector index of the current array access |
| arr_rdata | input | 8 | Data read from the array |
| rd_data | output | 8 | Gated read data |
| pe_req | input | 1 | Program or erase request |
| pe_go | output | 1 | Request granted |
| clr_sts | input | 1 | Clear strobe for the error flag |
| lock_err | output | 1 | Sticky sector-lock error |

## Verification
The hardest condition to reach is a mix of frozen and open sectors under changing pin levels. Random writes set lock-down quickly, and each frozen sector then stops all further register changes. Random stimulus therefore sets the lock-down bit in only a small share of writes, and it pulses `init_n` rarely so that sectors keep cycling back to the open state. Directed sequences cover a write that coincides with an access to the same sector, a frozen sector under rewrites, and a blocked request that lands on a clear strobe.

// File: rtl/lockctl_pkg.sv
package lockctl_pkg;
    // Field order matches the register layout: bit2 read lock, bit1 lock-down, bit0 write lock
    typedef struct packed {
        logic rd_lock;
        logic down;
        logic wr_lock;
    } lock_t;

    localparam int LOCK_W = $bits(lock_t);
    localparam lock_t LOCK_RESET = '{rd_lock: 1'b0, down: 1'b0, wr_lock: 1'b1};

    typedef enum logic {SEC_OPEN, SEC_FROZEN} sec_state_t;
    typedef enum logic {ERR_IDLE, ERR_FLAG} err_state_t;
endpackage

// File: rtl/sector_lock_reg.sv
module sector_lock_reg
    import lockctl_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  init_n,
    input  logic  wr_en,
    input  lock_t wdata,
    output lock_t q
);
    sec_state_t st, st_nx;
    logic rl_q, wl_q, rl_nx, wl_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st   <= SEC_OPEN;
            rl_q <= LOCK_RESET.rd_lock;
            wl_q <= LOCK_RESET.wr_lock;
        end else if (!init_n) begin
            st   <= SEC_OPEN;
            rl_q <= LOCK_RESET.rd_lock;
            wl_q <= LOCK_RESET.wr_lock;
        end else begin
            st   <= st_nx;
            rl_q <= rl_nx;
            wl_q <= wl_nx;
        end
    end

    always_comb begin
        st_nx = st;
        rl_nx = rl_q;
        wl_nx = wl_q;
        unique case (st)
            SEC_OPEN: begin
                if (wr_en) begin
                    rl_nx = wdata.rd_lock;
                    wl_nx = wdata.wr_lock;
                    if (wdata.down) st_nx = SEC_FROZEN;
                end
            end
            SEC_FROZEN: begin
                st_nx = SEC_FROZEN;
            end
            default: st_nx = SEC_OPEN;
        endcase
    end

    always_comb begin
        q.rd_lock = rl_q;
        q.down    = (st == SEC_FROZEN);
        q.wr_lock = wl_q;
    end

    // R5
    frozen_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.down && init_n) |=> (q.down && $stable(q)));

    // R6
    init_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!init_n) |=> (q == LOCK_RESET));
endmodule

// File: rtl/access_gate.sv
module access_gate
    import lockctl_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  lock_t             cur_lock,
    input  logic              is_top,
    input  logic              tbl_n,
    input  logic              wp_n,
    input  logic [DATA_W-1:0] arr_rdata,
    input  logic              pe_req,
    output logic [DATA_W-1:0] rd_data,
    output logic              pe_go,
    output logic              pe_blocked
);
    logic pin_lock;
    logic wr_eff;

    always_comb begin
        pin_lock   = is_top ? ~tbl_n : ~wp_n;
        wr_eff     = cur_lock.wr_lock | pin_lock;
        rd_data    = cur_lock.rd_lock ? '0 : arr_rdata;
        pe_go      = pe_req & ~wr_eff;
        pe_blocked = pe_req & wr_eff;
    end
endmodule

// File: rtl/err_tracker.sv
module err_tracker
    import lockctl_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic init_n,
    input  logic hit,
    input  logic clr,
    output logic flag
);
    err_state_t st, st_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       st <= ERR_IDLE;
        else if (!init_n) st <= ERR_IDLE;
        else              st <= st_nx;
    end

    always_comb begin
        st_nx = st;
        unique case (st)
            ERR_IDLE: if (hit) st_nx = ERR_FLAG;
            ERR_FLAG: if (clr && !hit) st_nx = ERR_IDLE;
            default:  st_nx = ERR_IDLE;
        endcase
    end

    always_comb flag = (st == ERR_FLAG);

    // R4
    err_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && init_n) |=> flag);

    // R9
    err_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !clr && init_n) |=> flag);
endmodule

// File: rtl/sector_lock_ctl.sv
module sector_lock_ctl
    import lockctl_pkg::*;
#(
    parameter int SECTORS = 8,
    parameter int DATA_W  = 8,
    localparam int SEL_W  = $clog2(SECTORS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              init_n,
    input  logic              tbl_n,
    input  logic              wp_n,
    input  logic              reg_wr,
    input  logic [SEL_W-1:0]  reg_sel,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic [SEL_W-1:0]  acc_sector,
    input  logic [DATA_W-1:0] arr_rdata,
    output logic [DATA_W-1:0] rd_data,
    input  logic              pe_req,
    output logic              pe_go,
    input  logic              clr_sts,
    output logic              lock_err
);
    localparam logic [SEL_W-1:0] TOP_SEC = SEL_W'(SECTORS - 1);

    lock_t locks [SECTORS];
    lock_t wr_val;
    lock_t cur_lock;
    logic  is_top;
    logic  pe_blocked;
    logic  unused_wdata_hi;

    assign wr_val          = reg_wdata[LOCK_W-1:0];
    assign unused_wdata_hi = ^reg_wdata[DATA_W-1:LOCK_W];

    for (genvar g = 0; g < SECTORS; g++) begin : g_sec
        sector_lock_reg u_reg (
            .clk    (clk),
            .rst_n  (rst_n),
            .init_n (init_n),
            .wr_en  (reg_wr && (reg_sel == SEL_W'(g))),
            .wdata  (wr_val),
            .q      (locks[g])
        );
    end

    always_comb begin
        reg_rdata             = '0;
        reg_rdata[LOCK_W-1:0] = locks[reg_sel];
        cur_lock              = locks[acc_sector];
        is_top                = (acc_sector == TOP_SEC);
    end

    access_gate #(.DATA_W(DATA_W)) u_gate (
        .cur_lock   (cur_lock),
        .is_top     (is_top),
        .tbl_n      (tbl_n),
        .wp_n       (wp_n),
        .arr_rdata  (arr_rdata),
        .pe_req     (pe_req),
        .rd_data    (rd_data),
        .pe_go      (pe_go),
        .pe_blocked (pe_blocked)
    );

    err_tracker u_err (
        .clk    (clk),
        .rst_n  (rst_n),
        .init_n (init_n),
        .hit    (pe_blocked),
        .clr    (clr_sts),
        .flag   (lock_err)
    );

    // R3
    rd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cur_lock.rd_lock |-> (rd_data == '0));

    // R7
    top_pin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!tbl_n && pe_req && is_top) |-> !pe_go);

    // R7
    wp_pin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!wp_n && pe_req && !is_top) |-> !pe_go);

    // R2
    hi_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rdata[DATA_W-1:LOCK_W] == '0);
endmodule

// File: tb/tb_sector_lock_ctl.sv
module tb_sector_lock_ctl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0, init_n = 1'b1, tbl_n = 1'b1, wp_n = 1'b1;
    logic       reg_wr = 1'b0, pe_req = 1'b0, clr_sts = 1'b0;
    logic [2:0] reg_sel = '0, acc_sector = '0;
    logic [7:0] reg_wdata = '0, arr_rdata = '0;
    logic [7:0] reg_rdata, rd_data;
    logic       pe_go, lock_err;

    int total = 0;
    int bad = 0;

    logic m_rl [8];
    logic m_wl [8];
    logic m_ld [8];
    logic m_err;

    always #2 clk = ~clk;

    sector_lock_ctl dut (
        .clk(clk), .rst_n(rst_n), .init_n(init_n), .tbl_n(tbl_n), .wp_n(wp_n),
        .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .acc_sector(acc_sector), .arr_rdata(arr_rdata), .rd_data(rd_data),
        .pe_req(pe_req), .pe_go(pe_go), .clr_sts(clr_sts), .lock_err(lock_err)
    );

    function automatic logic [7:0] exp_reg(int s);
        return {5'b0, m_rl[s], m_ld[s], m_wl[s]};
    endfunction

    function automatic logic exp_blocked(int s);
        return (s == 7) ? (m_wl[s] || !tbl_n) : (m_wl[s] || !wp_n);
    endfunction

    function automatic logic [7:0] exp_rd(int s);
        return m_rl[s] ? 8'h00 : arr_rdata;
    endfunction

    task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic model_reset();
        for (int i = 0; i < 8; i++) begin
            m_rl[i] = 1'b0; m_wl[i] = 1'b1; m_ld[i] = 1'b0;
        end
        m_err = 1'b0;
    endtask

    task automatic settle();
        #1;
    endtask

    // generic checks, model update for the coming edge, then move to next negedge
    task automatic advance();
        logic blk;
        check("R2 reg_rdata", reg_rdata, exp_reg(int'(reg_sel)));
        check("R3 rd_data", rd_data, exp_rd(int'(acc_sector)));
        check("R4 pe_go", {7'b0, pe_go}, {7'b0, pe_req && !exp_blocked(int'(acc_sector))});
        check("R9 lock_err", {7'b0, lock_err}, {7'b0, m_err});
        if (!init_n) begin
            model_reset();
        end else begin
            blk = pe_req && exp_blocked(int'(acc_sector));
            if (blk) m_err = 1'b1;
            else if (clr_sts) m_err = 1'b0;
            if (reg_wr && !m_ld[reg_sel]) begin
                m_wl[reg_sel] = reg_wdata[0];
                m_ld[reg_sel] = reg_wdata[1];
                m_rl[reg_sel] = reg_wdata[2];
            end
        end
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic idle();
        reg_wr = 1'b0; pe_req = 1'b0; clr_sts = 1'b0; init_n = 1'b1;
    endtask

    task automatic wr_reg(logic [2:0] s, logic [7:0] v);
        idle();
        reg_wr = 1'b1; reg_sel = s; reg_wdata = v;
        settle();
        advance();
        reg_wr = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        $display("FAIL watchdog: actual=expired expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset values of every register and the flag
        for (int s = 0; s < 8; s++) begin
            reg_sel = 3'(s);
            settle();
            check("R1 reset reg", reg_rdata, 8'h01);
            check("R1 reset err", {7'b0, lock_err}, 8'h00);
            advance();
        end

        // R7: wp_n blocks an unlocked lower sector, pins invisible in register
        wr_reg(3'd2, 8'h00);
        wr_reg(3'd7, 8'h00);
        idle(); wp_n = 1'b0; tbl_n = 1'b1; pe_req = 1'b1; acc_sector = 3'd2; reg_sel = 3'd2;
        settle();
        check("R7 wp blocks", {7'b0, pe_go}, 8'h00);
        check("R7 pin hidden", reg_rdata, 8'h00);
        advance();
        idle(); clr_sts = 1'b1; settle(); advance();
        idle(); wp_n = 1'b1; tbl_n = 1'b0; pe_req = 1'b1; acc_sector = 3'd7; reg_sel = 3'd7;
        settle();
        check("R7 tbl blocks top", {7'b0, pe_go}, 8'h00);
        check("R7 pin hidden top", reg_rdata, 8'h00);
        advance();
        idle(); tbl_n = 1'b0; pe_req = 1'b1; acc_sector = 3'd2;
        settle();
        check("R7 tbl spares lower", {7'b0, pe_go}, 8'h01);
        advance();
        idle(); tbl_n = 1'b1; clr_sts = 1'b1; settle(); advance();

        // R8: write read lock while reading same sector
        idle(); reg_wr = 1'b1; reg_sel = 3'd3; reg_wdata = 8'h04; acc_sector = 3'd3; arr_rdata = 8'hA5;
        settle();
        check("R8 old state read", rd_data, 8'hA5);
        advance();
        idle(); acc_sector = 3'd3; arr_rdata = 8'h5A;
        settle();
        check("R8 new state read", rd_data, 8'h00);
        check("R3 no error on locked read", {7'b0, lock_err}, 8'h00);
        advance();

        // R5: lock-down freezes the register
        wr_reg(3'd4, 8'h02);
        wr_reg(3'd4, 8'h05);
        wr_reg(3'd4, 8'h00);
        idle(); reg_sel = 3'd4;
        settle();
        check("R5 frozen", reg_rdata, 8'h02);
        advance();

        // R9: blocked request coinciding with clear keeps flag
        idle(); pe_req = 1'b1; acc_sector = 3'd0; clr_sts = 1'b1;
        settle(); advance();
        idle(); settle();
        check("R9 set wins over clear", {7'b0, lock_err}, 8'h01);
        advance();
        idle(); settle();
        check("R9 sticky", {7'b0, lock_err}, 8'h01);
        advance();

        // R6: init clears lock-down and flag
        idle(); init_n = 1'b0; settle(); advance();
        idle(); reg_sel = 3'd4; settle();
        check("R6 init clears reg", reg_rdata, 8'h01);
        check("R6 init clears err", {7'b0, lock_err}, 8'h00);
        advance();
        wr_reg(3'd4, 8'h00);
        idle(); reg_sel = 3'd4; settle();
        check("R6 writable after init", reg_rdata, 8'h00);
        advance();

        // constrained random mix
        for (int n = 0; n < 4000; n++) begin
            reg_wr     = ($urandom % 4) == 0;
            reg_sel    = 3'($urandom);
            reg_wdata  = 8'($urandom);
            if (($urandom % 8) != 0) reg_wdata[1] = 1'b0;
            acc_sector = 3'($urandom);
            arr_rdata  = 8'($urandom);
            pe_req     = ($urandom % 2) == 0;
            tbl_n      = ($urandom % 4) != 0;
            wp_n       = ($urandom % 4) != 0;
            clr_sts    = ($urandom % 8) == 0;
            init_n     = ($urandom % 64) != 0;
            settle();
            advance();
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule